// File: doc/BRIEF.md
# Coprocessor-0 Exception Entry Sequencer

This block is the exception-entry half of a 32-bit MIPS-like system control coprocessor. It keeps six architected registers: Status, Cause, EPC, BadVAddr, Context and EntryHi. It merges a masked interrupt-controller request into the pending interrupt bit of Cause and decides each cycle whether an interrupt can be taken. When a TLB miss, coprocessor-unusable fault, syscall or interrupt is accepted, all affected registers update on that clock edge. On the next cycle the block presents a one-cycle redirect pulse with the vector address.

The pipeline supplies the PC of the excepting instruction, a delay-slot flag, the event strobes, the faulting virtual address and a flag that says whether some TLB entry covers that address. A small write port lets the core load Status and Context.

Control is a two-state machine. RUN is the state in which events are accepted. FLUSH lasts exactly one cycle and drives the redirect. The transitions are: RUN to FLUSH when any event is accepted (named ACCEPT), RUN to RUN when no event is present (named IDLE), and FLUSH to RUN always (named RESUME). Event strobes that arrive in FLUSH are dropped.

Top module: `trap_sequencer`

## Requirements
- R1: After reset: Status = 0x34000000, Cause = 0x0000005C, Context = 0x007FFFF0, EPC = BadVAddr = 0xFFFFFFFF, EntryHi = 0, redirect_valid = 0.
- R2: Every clock edge loads Cause bit 10 with the OR of (irq_req AND irq_mask) as sampled at that edge. This holds on exception-entry edges too.
- R3: An interrupt is accepted only in RUN, and only when Status bit 0 (IE) = 1, Status bit 1 (EXL) = 0, Status bit 2 (ERL) = 0 and (Status[15:8] AND Cause[15:8]) is nonzero. On entry, Cause = Cause[15:8] kept, code 0 in Cause[6:2], plus BD.
- R4: On any entry that writes EPC: if in_delay_slot = 1, Cause bit 31 (BD) = 1 and EPC = cur_pc − 4. Otherwise BD = 0 and EPC = cur_pc.
- R5: Interrupt, syscall and coprocessor-unusable entries set Status bit 1 (EXL) and redirect to 0x80000180. Syscall writes code 8 in Cause[6:2]. Coprocessor-unusable writes code 11. Other Cause bits are cleared apart from BD and bit 10.
- R6: A coprocessor-unusable entry with cop_index = 1 also sets Cause bit 28. Any other index leaves bit 28 at 0.
- R7: On a TLB miss: BadVAddr = fault_addr, EntryHi = fault_addr & 0xFFFFE000, Context = (Context & 0xFF80000F) | ((fault_addr >> 9) & 0x007FFFF0), and Cause[6:2] = 2.
- R8: If a TLB miss occurs with EXL = 0, EPC and BD update per R4 and EXL is set. The vector is 0x80000180 when tlb_covers = 1 and 0x80000000 otherwise. If the miss occurs with EXL = 1, EPC and Status are unchanged, BD = 0, and the vector is 0x80000180.
- R9: When several events coincide, the priority is TLB miss > coprocessor-unusable > syscall > interrupt. Each accepted event gives exactly one redirect_valid pulse, in the cycle after the accepting edge. Strobes in that pulse cycle are ignored.
- R10: csr_wr_en with csr_wr_sel = 0 loads Status and with csr_wr_sel = 1 loads Context. The write is ignored on an edge where an event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | PC of the excepting instruction |
| in_delay_slot | input | 1 | Instruction sits in a branch delay slot |
| ev_tlb_miss | input | 1 | TLB miss strobe |
| ev_cop_unusable | input | 1 | Coprocessor-unusable strobe |
| cop_index | input | 2 | Coprocessor number for the unusable fault |
| ev_syscall | input | 1 | Syscall strobe |
| fault_addr | input | 32 | Faulting virtual address |
| tlb_covers | input | 1 | Some TLB entry matches fault_addr |
| irq_req | input | IRQ_W | Interrupt-controller request lines |
| irq_mask | input | IRQ_W | Interrupt-controller mask |
| csr_wr_en | input | 1 | Register write enable |
| csr_wr_sel | input | 1 | 0 = Status, 1 = Context |
| csr_wr_data | input | 32 | Write data |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception PC |
| badvaddr_o | output | 32 | Bad virtual address |
| context_o | output | 32 | Context register |
| entryhi_o | output | 32 | EntryHi register |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | Redirect vector |

## Verification
All state is registered, so a wrong update shows up at the register outputs one cycle after the edge that caused it. Examples are a stale EXL, a misplaced code field, or a Context bit leaking through the keep mask. A wrong pending bit or enable decision is delayed one cycle more: it appears as a missing, extra or early redirect pulse, together with a wrong EPC. A broken FLUSH state shows as a doubled pulse, or as a second event overwriting EPC in the cycle right after the first. The bench predicts every output each cycle, so each such fault is caught in the cycle it first reaches a port.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XW = 32;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_TLB  = 3'd1,
        EV_CPU  = 3'd2,
        EV_SYS  = 3'd3,
        EV_INT  = 3'd4
    } ev_kind_t;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } seq_state_t;

    localparam logic [4:0] CODE_INT  = 5'd0;
    localparam logic [4:0] CODE_TLBL = 5'd2;
    localparam logic [4:0] CODE_SYS  = 5'd8;
    localparam logic [4:0] CODE_CPU  = 5'd11;

    localparam int SR_IE  = 0;
    localparam int SR_EXL = 1;
    localparam int SR_ERL = 2;
    localparam int CR_BD  = 31;
    localparam int CR_CE1 = 28;
    localparam int CR_IP2 = 10;
    localparam int CODE_LSB = 2;

    localparam logic [XW-1:0] RST_STATUS = 32'h3400_0000;
    localparam logic [XW-1:0] RST_CAUSE  = 32'h0000_005C;
    localparam logic [XW-1:0] RST_CTX    = 32'h007F_FFF0;
    localparam logic [XW-1:0] RST_ALL1   = 32'hFFFF_FFFF;

    localparam logic [XW-1:0] IP_FIELD   = 32'h0000_FF00;
    localparam logic [XW-1:0] CTX_KEEP   = 32'hFF80_000F;
    localparam logic [XW-1:0] CTX_VPN    = 32'h007F_FFF0;
    localparam logic [XW-1:0] EHI_MASK   = 32'hFFFF_E000;
    localparam int            CTX_SHIFT  = 9;

    localparam logic [XW-1:0] VEC_GENERAL = 32'h8000_0180;
    localparam logic [XW-1:0] VEC_REFILL  = 32'h8000_0000;
endpackage

// File: rtl/trap_irq_gate.sv
module trap_irq_gate
    import trap_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_W-1:0]  irq_req,
    input  logic [IRQ_W-1:0]  irq_mask,
    input  logic [XW-1:0]     status,
    input  logic [XW-1:0]     cause,
    output logic              pend_next,
    output logic              int_take
);
    logic enabled;

    always_comb begin
        pend_next = |(irq_req & irq_mask);
        enabled   = status[SR_IE] && !status[SR_EXL] && !status[SR_ERL];
        int_take  = enabled && ((status & cause & IP_FIELD) != '0);
    end

    // R3
    blocked_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[SR_IE] || status[SR_EXL] || status[SR_ERL]) |-> !int_take);

    // R2
    ip2_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_next |=> cause[CR_IP2]);
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     ev_tlb,
    input  logic     ev_cpu,
    input  logic     ev_sys,
    input  logic     int_take,
    output ev_kind_t sel
);
    always_comb begin
        sel = EV_NONE;
        if (enable) begin
            if (ev_tlb)        sel = EV_TLB;
            else if (ev_cpu)   sel = EV_CPU;
            else if (ev_sys)   sel = EV_SYS;
            else if (int_take) sel = EV_INT;
        end
    end

    // R9
    tlb_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ev_tlb) |-> sel == EV_TLB);

    // R9
    no_accept_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> sel == EV_NONE);
endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  ev_kind_t      sel,
    input  logic [XW-1:0] cur_pc,
    input  logic          in_delay_slot,
    input  logic [1:0]    cop_index,
    input  logic [XW-1:0] fault_addr,
    input  logic          tlb_covers,
    input  logic          pend_next,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [XW-1:0] wr_data,
    output logic [XW-1:0] status,
    output logic [XW-1:0] cause,
    output logic [XW-1:0] epc,
    output logic [XW-1:0] badvaddr,
    output logic [XW-1:0] context_r,
    output logic [XW-1:0] entryhi,
    output logic [XW-1:0] vector
);
    logic [XW-1:0] n_status, n_cause, n_epc, n_bad, n_ctx, n_ehi;
    logic [XW-1:0] entry_epc;
    logic [XW-1:0] bd_word;

    function automatic logic [XW-1:0] code_word(input logic [4:0] code);
        logic [XW-1:0] w;
        w = '0;
        w[CODE_LSB +: 5] = code;
        return w;
    endfunction

    always_comb begin
        entry_epc = in_delay_slot ? (cur_pc - 32'd4) : cur_pc;
        bd_word   = '0;
        bd_word[CR_BD] = in_delay_slot;

        n_status = status;
        n_cause  = cause;
        n_epc    = epc;
        n_bad    = badvaddr;
        n_ctx    = context_r;
        n_ehi    = entryhi;

        unique case (sel)
            EV_NONE: begin
                if (wr_en && !wr_sel) n_status = wr_data;
                if (wr_en &&  wr_sel) n_ctx    = wr_data;
            end
            EV_INT: begin
                n_cause = (cause & IP_FIELD) | code_word(CODE_INT) | bd_word;
                n_epc   = entry_epc;
                n_status[SR_EXL] = 1'b1;
            end
            EV_SYS: begin
                n_cause = code_word(CODE_SYS) | bd_word;
                n_epc   = entry_epc;
                n_status[SR_EXL] = 1'b1;
            end
            EV_CPU: begin
                n_cause = code_word(CODE_CPU) | bd_word;
                n_cause[CR_CE1] = (cop_index == 2'd1);
                n_epc   = entry_epc;
                n_status[SR_EXL] = 1'b1;
            end
            EV_TLB: begin
                n_bad   = fault_addr;
                n_ehi   = fault_addr & EHI_MASK;
                n_ctx   = (context_r & CTX_KEEP) | ((fault_addr >> CTX_SHIFT) & CTX_VPN);
                n_cause = code_word(CODE_TLBL);
                if (!status[SR_EXL]) begin
                    n_cause = n_cause | bd_word;
                    n_epc   = entry_epc;
                    n_status[SR_EXL] = 1'b1;
                end
            end
            default: begin
                n_status = status;
            end
        endcase

        n_cause[CR_IP2] = pend_next;

        if (sel == EV_TLB && !status[SR_EXL] && !tlb_covers) vector = VEC_REFILL;
        else                                                   vector = VEC_GENERAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status    <= RST_STATUS;
            cause     <= RST_CAUSE;
            epc       <= RST_ALL1;
            badvaddr  <= RST_ALL1;
            context_r <= RST_CTX;
            entryhi   <= '0;
        end else begin
            status    <= n_status;
            cause     <= n_cause;
            epc       <= n_epc;
            badvaddr  <= n_bad;
            context_r <= n_ctx;
            entryhi   <= n_ehi;
        end
    end

    // R7
    ehi_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel == EV_TLB |=> entryhi[12:0] == '0 && badvaddr == $past(fault_addr));

    // R8
    nested_tlb_keeps_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EV_TLB && status[SR_EXL]) |=> $stable(epc) && !cause[CR_BD]);

    // R4
    slot_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel inside {EV_INT, EV_SYS, EV_CPU} && in_delay_slot) |=>
            epc == $past(cur_pc) - 32'd4 && cause[CR_BD]);

    // R5
    exl_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel inside {EV_INT, EV_SYS, EV_CPU} |=> status[SR_EXL]);
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cur_pc,
    input  logic              in_delay_slot,
    input  logic              ev_tlb_miss,
    input  logic              ev_cop_unusable,
    input  logic [1:0]        cop_index,
    input  logic              ev_syscall,
    input  logic [31:0]       fault_addr,
    input  logic              tlb_covers,
    input  logic [IRQ_W-1:0]  irq_req,
    input  logic [IRQ_W-1:0]  irq_mask,
    input  logic              csr_wr_en,
    input  logic              csr_wr_sel,
    input  logic [31:0]       csr_wr_data,
    output logic [31:0]       status_o,
    output logic [31:0]       cause_o,
    output logic [31:0]       epc_o,
    output logic [31:0]       badvaddr_o,
    output logic [31:0]       context_o,
    output logic [31:0]       entryhi_o,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc
);
    seq_state_t    state, state_n;
    ev_kind_t      sel;
    logic          pend_next, int_take;
    logic [XW-1:0] vector;

    trap_irq_gate #(.IRQ_W(IRQ_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .irq_mask  (irq_mask),
        .status    (status_o),
        .cause     (cause_o),
        .pend_next (pend_next),
        .int_take  (int_take)
    );

    trap_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (state == ST_RUN),
        .ev_tlb   (ev_tlb_miss),
        .ev_cpu   (ev_cop_unusable),
        .ev_sys   (ev_syscall),
        .int_take (int_take),
        .sel      (sel)
    );

    trap_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (sel),
        .cur_pc        (cur_pc),
        .in_delay_slot (in_delay_slot),
        .cop_index     (cop_index),
        .fault_addr    (fault_addr),
        .tlb_covers    (tlb_covers),
        .pend_next     (pend_next),
        .wr_en         (csr_wr_en),
        .wr_sel        (csr_wr_sel),
        .wr_data       (csr_wr_data),
        .status        (status_o),
        .cause         (cause_o),
        .epc           (epc_o),
        .badvaddr      (badvaddr_o),
        .context_r     (context_o),
        .entryhi       (entryhi_o),
        .vector        (vector)
    );

    // next-state: ACCEPT, IDLE, RESUME
    always_comb begin
        state_n = state;
        unique case (state)
            ST_RUN:   state_n = (sel != EV_NONE) ? ST_FLUSH : ST_RUN;
            ST_FLUSH: state_n = ST_RUN;
            default:  state_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= VEC_GENERAL;
        end else begin
            redirect_valid <= (sel != EV_NONE);
            if (sel != EV_NONE) redirect_pc <= vector;
        end
    end

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // R9
    pulse_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid == (state == ST_FLUSH));

    // R8
    refill_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && redirect_pc == VEC_REFILL) |-> cause_o[6:2] == CODE_TLBL);
endmodule

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        in_delay_slot = 1'b0;
    logic        ev_tlb_miss = 1'b0, ev_cop_unusable = 1'b0, ev_syscall = 1'b0;
    logic [1:0]  cop_index = '0;
    logic [31:0] fault_addr = '0;
    logic        tlb_covers = 1'b0;
    logic [7:0]  irq_req = '0, irq_mask = '0;
    logic        csr_wr_en = 1'b0, csr_wr_sel = 1'b0;
    logic [31:0] csr_wr_data = '0;
    logic [31:0] status_o, cause_o, epc_o, badvaddr_o, context_o, entryhi_o, redirect_pc;
    logic        redirect_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #5 clk = ~clk;

    trap_sequencer #(.IRQ_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .in_delay_slot(in_delay_slot),
        .ev_tlb_miss(ev_tlb_miss), .ev_cop_unusable(ev_cop_unusable), .cop_index(cop_index),
        .ev_syscall(ev_syscall), .fault_addr(fault_addr), .tlb_covers(tlb_covers),
        .irq_req(irq_req), .irq_mask(irq_mask), .csr_wr_en(csr_wr_en),
        .csr_wr_sel(csr_wr_sel), .csr_wr_data(csr_wr_data), .status_o(status_o),
        .cause_o(cause_o), .epc_o(epc_o), .badvaddr_o(badvaddr_o), .context_o(context_o),
        .entryhi_o(entryhi_o), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    // reference model state
    logic [31:0] m_st, m_ca, m_epc, m_bad, m_ctx, m_ehi, m_rpc;
    bit          m_rv, m_flush;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 32'h3400_0000; m_ca = 32'h0000_005C; m_epc = 32'hFFFF_FFFF;
            m_bad = 32'hFFFF_FFFF; m_ctx = 32'h007F_FFF0; m_ehi = 0;
            m_rv = 0; m_flush = 0; m_rpc = 32'h8000_0180;
        end else begin
            logic [31:0] o_st, o_ca, pc_e, bd;
            bit pend, take, acc, nested;
            o_st = m_st; o_ca = m_ca;
            pend = (irq_req & irq_mask) != 0;
            take = o_st[0] && !o_st[1] && !o_st[2] && ((o_st[15:8] & o_ca[15:8]) != 0);
            pc_e = in_delay_slot ? cur_pc - 4 : cur_pc;
            bd   = in_delay_slot ? 32'h8000_0000 : 0;
            acc  = 0;
            if (!m_flush) begin
                if (ev_tlb_miss) begin
                    acc = 1;
                    nested = o_st[1];
                    m_bad = fault_addr;
                    m_ehi = {fault_addr[31:13], 13'b0};
                    m_ctx = (m_ctx & 32'hFF80_000F) | ((fault_addr / 512) & 32'h007F_FFF0);
                    m_ca  = 2 * 4;
                    if (!nested) begin
                        m_ca = m_ca | bd; m_epc = pc_e; m_st[1] = 1;
                        m_rpc = tlb_covers ? 32'h8000_0180 : 32'h8000_0000;
                    end else m_rpc = 32'h8000_0180;
                end else if (ev_cop_unusable) begin
                    acc = 1; m_ca = 11 * 4 | bd | (cop_index == 1 ? 32'h1000_0000 : 0);
                    m_epc = pc_e; m_st[1] = 1; m_rpc = 32'h8000_0180;
                end else if (ev_syscall) begin
                    acc = 1; m_ca = 8 * 4 | bd;
                    m_epc = pc_e; m_st[1] = 1; m_rpc = 32'h8000_0180;
                end else if (take) begin
                    acc = 1; m_ca = (o_ca & 32'h0000_FF00) | bd;
                    m_epc = pc_e; m_st[1] = 1; m_rpc = 32'h8000_0180;
                end
            end
            if (!acc && csr_wr_en) begin
                if (csr_wr_sel) m_ctx = csr_wr_data;
                else            m_st  = csr_wr_data;
            end
            m_ca[10] = pend;
            m_rv = acc;
            m_flush = acc;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk("R5 status", status_o, m_st);
            chk("R3 cause", cause_o, m_ca);
            chk("R4 epc", epc_o, m_epc);
            chk("R7 badvaddr", badvaddr_o, m_bad);
            chk("R7 context", context_o, m_ctx);
            chk("R7 entryhi", entryhi_o, m_ehi);
            chk("R9 redirect_valid", {31'b0, redirect_valid}, {31'b0, m_rv});
            if (m_rv) chk("R8 redirect_pc", redirect_pc, m_rpc);
        end
    end

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        csr_wr_en = 1; csr_wr_sel = sel; csr_wr_data = d;
        @(negedge clk);
        csr_wr_en = 0;
    endtask

    task automatic pulse(input bit t, input bit c, input bit s);
        ev_tlb_miss = t; ev_cop_unusable = c; ev_syscall = s;
        @(negedge clk);
        ev_tlb_miss = 0; ev_cop_unusable = 0; ev_syscall = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        // R1 reset state
        chk("R1 status", status_o, 32'h3400_0000);
        chk("R1 cause", cause_o, 32'h0000_005C);
        chk("R1 context", context_o, 32'h007F_FFF0);
        chk("R1 epc", epc_o, 32'hFFFF_FFFF);
        chk("R1 badvaddr", badvaddr_o, 32'hFFFF_FFFF);
        chk("R1 entryhi", entryhi_o, 0);
        chk("R1 redirect", {31'b0, redirect_valid}, 0);

        // syscall, not in slot
        cur_pc = 32'h1000;
        pulse(0, 0, 1);
        chk("R5 sys status", status_o, 32'h3400_0002);
        chk("R5 sys cause", cause_o, 32'h20);
        chk("R4 sys epc", epc_o, 32'h1000);
        chk("R5 sys vector", redirect_pc, 32'h8000_0180);
        // strobe in flush cycle is dropped
        cur_pc = 32'h5000;
        pulse(0, 0, 1);
        chk("R9 flush ignores", {31'b0, redirect_valid}, 0);
        chk("R9 flush epc", epc_o, 32'h1000);

        // R10 status write
        wr(0, 32'h0000_0401);
        chk("R10 status write", status_o, 32'h0000_0401);

        // R2 pending, then R3 interrupt in a delay slot
        irq_req = 8'h04; irq_mask = 8'h04; cur_pc = 32'h2000; in_delay_slot = 1;
        idle();
        chk("R2 ip2 set", cause_o, 32'h0000_0420);
        chk("R3 not yet", {31'b0, redirect_valid}, 0);
        idle();
        chk("R3 int cause", cause_o, 32'h8000_0400);
        chk("R4 int epc", epc_o, 32'h0000_1FFC);
        chk("R3 int taken", {31'b0, redirect_valid}, 1);
        irq_req = 0; in_delay_slot = 0;
        idle();
        chk("R2 ip2 clear", cause_o, 32'h8000_0000);

        // ERL blocks interrupt
        wr(0, 32'h0000_0405);
        irq_req = 8'h04;
        repeat (4) begin
            idle();
            chk("R3 erl blocks", {31'b0, redirect_valid}, 0);
        end
        irq_req = 0;
        wr(0, 0);

        // R6 coprocessor 1 unusable
        cur_pc = 32'h3000; cop_index = 1;
        pulse(0, 1, 0);
        chk("R6 cpu1 cause", cause_o, 32'h1000_002C);
        chk("R5 cpu exl", status_o, 32'h0000_0002);
        idle();
        wr(0, 0);

        // R7/R8 refill miss
        cur_pc = 32'h4000; fault_addr = 32'h1234_5678; tlb_covers = 0;
        pulse(1, 0, 0);
        chk("R7 bad", badvaddr_o, 32'h1234_5678);
        chk("R7 ehi", entryhi_o, 32'h1234_4000);
        chk("R7 ctx", context_o, 32'h0009_1A20);
        chk("R8 refill vec", redirect_pc, 32'h8000_0000);
        idle();
        // nested miss
        cur_pc = 32'h5000; in_delay_slot = 1; fault_addr = 32'hFFFF_F000;
        pulse(1, 0, 0);
        in_delay_slot = 0;
        chk("R8 nested epc", epc_o, 32'h4000);
        chk("R8 nested cause", cause_o, 32'h08);
        chk("R8 nested vec", redirect_pc, 32'h8000_0180);
        idle();
        wr(0, 0);
        tlb_covers = 1; fault_addr = 32'h0040_2000;
        pulse(1, 0, 0);
        chk("R8 covered vec", redirect_pc, 32'h8000_0180);
        idle();

        // R9 priority
        wr(0, 0);
        cop_index = 0;
        pulse(1, 1, 1);
        chk("R9 tlb first", cause_o, 32'h08);
        idle(); wr(0, 0);
        pulse(0, 1, 1);
        chk("R9 cpu before sys", cause_o, 32'h2C);
        idle(); wr(0, 0);

        // R10 write ignored on accept
        csr_wr_en = 1; csr_wr_sel = 1; csr_wr_data = 32'hAAAA_5555;
        pulse(0, 0, 1);
        csr_wr_en = 0;
        chk("R10 ctx write dropped", context_o, m_ctx);
        idle();

        // random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            cur_pc = $urandom & 32'hFFFF_FFFC;
            in_delay_slot = $urandom_range(0, 1);
            fault_addr = $urandom;
            tlb_covers = $urandom_range(0, 1);
            cop_index = 2'($urandom_range(0, 3));
            irq_req = 8'($urandom); irq_mask = 8'($urandom_range(0, 3) == 0 ? 8'h04 : 8'h00);
            ev_tlb_miss = (r == 1); ev_cop_unusable = (r == 2 || r == 4); ev_syscall = (r == 3 || r == 4);
            csr_wr_en = (r >= 12); csr_wr_sel = (r == 15);
            case ($urandom_range(0, 3))
                0: csr_wr_data = 32'h0000_0401;
                1: csr_wr_data = 32'h0000_FF01;
                2: csr_wr_data = 32'h0000_0405;
                default: csr_wr_data = $urandom;
            endcase
            @(negedge clk);
        end
        ev_tlb_miss = 0; ev_cop_unusable = 0; ev_syscall = 0; csr_wr_en = 0;
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule